// File: doc/BRIEF.md
# SPI Serial Clock Divider and Interval Timer

This block holds one 16-bit down-counter that runs on the system clock and serves two purposes. When the serial port is enabled and acting as the bus master with a transfer in flight, the counter paces the serial clock. Each time it expires it reloads, flips SCK and gives a one-cycle strobe to the shift logic. One full SCK period therefore spans twice the reload value in system clocks.

When the serial port is disabled, the same counter runs freely as an interval timer and gives a one-cycle timeout pulse each time it expires. Software loads the 16-bit reload value through two byte-wide write strobes, one for the upper byte and one for the lower byte.

While the port is enabled but not actively clocking a transfer, SCK sits at the selected idle level and the counter is preloaded, so the first edge comes exactly one half period after the transfer starts.

Top module: `spi_brg_timer`

## Requirements
- R1: The reload value is the upper-byte register in bits 15:8 and the lower-byte register in bits 7:0. A strobe on `wr_hi` or `wr_lo` captures `wr_byte` into that byte at the next clock edge. Both bytes reset to 0.
- R2: While running a transfer (`spi_en`=1, `master_mode`=1, `xfer_busy`=1) with an effective reload N, `half_tick` is high for one cycle every N cycles. SCK inverts at the clock edge that ends each `half_tick` cycle. The first `half_tick` falls in cycle N-1, counting from 0 at the first cycle with `xfer_busy` high.
- R3: In serial mode, a reload value below 2 is treated as 2, so SCK is never faster than the system clock divided by 4 and two `half_tick` pulses are never adjacent.
- R4: When `spi_en`=1 but there is no running transfer (slave mode or `xfer_busy`=0), SCK follows `cpol` one cycle later. `half_tick` and `timeout` stay low, and the counter is held at the serial-mode effective reload value.
- R5: When `spi_en`=0, `timeout` pulses for one cycle every N cycles, where N is the reload value. The first pulse falls at cycle L-1 after leaving the idle serial state, where L is the value preloaded there. SCK stays at `cpol` and `half_tick` stays low.
- R6: In timer mode a reload value of 0 gives a period of 65536 cycles.
- R7: A write to a byte register during a count does not alter the count in progress. The new value is used from the next reload onward.
- R8: `half_tick` and `timeout` are never high together, and `timeout` is high only while `spi_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_en | input | 1 | Serial port enabled; 0 selects timer use |
| master_mode | input | 1 | Port acts as bus master |
| xfer_busy | input | 1 | A transfer is in progress |
| cpol | input | 1 | Idle level of SCK |
| wr_hi | input | 1 | Write strobe for the reload upper byte |
| wr_lo | input | 1 | Write strobe for the reload lower byte |
| wr_byte | input | 8 | Byte written by either strobe |
| sck | output | 1 | Serial clock |
| half_tick | output | 1 | One-cycle strobe in the cycle before each SCK edge |
| timeout | output | 1 | One-cycle timer expiry pulse |

## Verification
A corrupted counter value shows up at the ports as a misplaced `half_tick` or `timeout`, no later than one reload period after the fault. A wrong reload byte or a missed byte capture shifts every following period by a measurable number of cycles, and a high-byte fault changes it by multiples of 256. A wrong SCK state shows as a polarity mismatch on the very next sample, either against `cpol` when idle or against the count of edges since the transfer started. The bench therefore predicts every cycle of each sweep arithmetically and compares each output on every cycle.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER    = 2'd0,
    MODE_SPI_IDLE = 2'd1,
    MODE_SPI_RUN  = 2'd2
  } brg_mode_e;

  localparam int unsigned BRG_SPI_MIN = 2;

  function automatic brg_mode_e decode_mode(input logic en, input logic mst, input logic busy);
    if (!en) return MODE_TIMER;
    if (mst && busy) return MODE_SPI_RUN;
    return MODE_SPI_IDLE;
  endfunction
endpackage

// File: rtl/brg_reload_regs.sv
module brg_reload_regs #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [W-1:0]      reload_raw,
  output logic [W-1:0]      reload_spi
);
  import spi_brg_pkg::*;

  function automatic logic [W-1:0] clamp_spi(input logic [W-1:0] v);
    return (v < W'(BRG_SPI_MIN)) ? W'(BRG_SPI_MIN) : v;
  endfunction

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byte_q <= '0;
      else if (wr_en[g]) byte_q <= wr_byte;
    end
    assign reload_raw[g*BYTE_W +: BYTE_W] = byte_q;

    assert_byte_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> (byte_q == $past(wr_byte)));
  end

  assign reload_spi = clamp_spi(reload_raw);
endmodule

// File: rtl/brg_down_counter.sv
module brg_down_counter #(
  parameter int unsigned W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  spi_brg_pkg::brg_mode_e mode,
  input  logic [W-1:0]          reload_raw,
  input  logic [W-1:0]          reload_spi,
  output logic [W-1:0]          count,
  output logic                  expire
);
  import spi_brg_pkg::*;

  function automatic logic [W-1:0] next_count(input brg_mode_e m, input logic [W-1:0] c,
                                              input logic ex, input logic [W-1:0] rr,
                                              input logic [W-1:0] rs);
    case (m)
      MODE_SPI_IDLE: return rs;
      MODE_SPI_RUN:  return ex ? rs : c - W'(1);
      default:       return ex ? rr : c - W'(1);
    endcase
  endfunction

  assign expire = (mode != MODE_SPI_IDLE) && (count == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(mode, count, expire, reload_raw, reload_spi);
  end

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPI_IDLE) |=> (count == $past(reload_spi)));
  assert_timer_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode == MODE_TIMER) |=> (count == $past(reload_raw)));
  assert_spi_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode == MODE_SPI_RUN) |=> (count >= W'(BRG_SPI_MIN)));
endmodule

// File: rtl/brg_sck_gen.sv
module brg_sck_gen (
  input  logic                  clk,
  input  logic                  rst_n,
  input  spi_brg_pkg::brg_mode_e mode,
  input  logic                  cpol,
  input  logic                  expire,
  output logic                  sck,
  output logic                  half_tick,
  output logic                  timeout
);
  import spi_brg_pkg::*;

  assign half_tick = expire && (mode == MODE_SPI_RUN);
  assign timeout   = expire && (mode == MODE_TIMER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sck <= 1'b0;
    else if (mode != MODE_SPI_RUN) sck <= cpol;
    else if (half_tick)            sck <= ~sck;
  end

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_SPI_RUN) |=> (sck == $past(cpol)));
  assert_edge_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> (sck != $past(sck)));
  assert_no_hold_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SPI_RUN && !half_tick) |=> $stable(sck));
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);
endmodule

// File: rtl/spi_brg_timer.sv
module spi_brg_timer #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NBYTES = 2,
  localparam int unsigned CNT_W  = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_en,
  input  logic              master_mode,
  input  logic              xfer_busy,
  input  logic              cpol,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              sck,
  output logic              half_tick,
  output logic              timeout
);
  import spi_brg_pkg::*;

  brg_mode_e        mode;
  logic [CNT_W-1:0] reload_raw;
  logic [CNT_W-1:0] reload_spi;
  logic [CNT_W-1:0] count;
  logic             expire;

  assign mode = decode_mode(spi_en, master_mode, xfer_busy);

  brg_reload_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en({wr_hi, wr_lo}), .wr_byte(wr_byte),
    .reload_raw(reload_raw), .reload_spi(reload_spi)
  );

  brg_down_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reload_raw(reload_raw),
    .reload_spi(reload_spi), .count(count), .expire(expire)
  );

  brg_sck_gen u_sck (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cpol(cpol), .expire(expire),
    .sck(sck), .half_tick(half_tick), .timeout(timeout)
  );

  assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_tick && timeout));
  assert_timeout_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !spi_en);
  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && count == '0) |=> (count != '0));
endmodule

// File: tb/spi_brg_timer_test.sv
module spi_brg_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_en = 1'b1, master_mode = 1'b0, xfer_busy = 1'b0, cpol = 1'b0;
  logic wr_hi = 1'b0, wr_lo = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic sck, half_tick, timeout;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_brg_timer uut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .master_mode(master_mode),
    .xfer_busy(xfer_busy), .cpol(cpol), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_byte(wr_byte), .sck(sck), .half_tick(half_tick), .timeout(timeout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int spi_eff(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int timer_eff(input int n);
    return (n == 0) ? 65536 : n;
  endfunction

  task automatic write_reload(input int v);
    @(negedge clk); wr_hi = 1'b1; wr_byte = v[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_byte = v[7:0];
    @(negedge clk); wr_lo = 1'b0;
    @(negedge clk);
  endtask

  // Timer sweep: optional lower-byte rewrite at cycle wr_at (R7)
  task automatic run_timer(input int n, input int ncyc, input int wr_at, input int new_n,
                           input string req);
    int next_ev;
    spi_en = 1'b1; master_mode = 1'b0; xfer_busy = 1'b0;
    write_reload(n);
    @(negedge clk);
    spi_en = 1'b0;
    next_ev = spi_eff(n) - 1;
    for (int i = 0; i <= ncyc; i++) begin
      logic exp_to;
      #1;
      exp_to = (i == next_ev);
      if (exp_to || timeout !== exp_to)
        check(timeout === exp_to, req, timeout, exp_to);
      if (sck !== cpol || half_tick !== 1'b0) begin
        check(sck === cpol, "R5 sck", sck, cpol);
        check(half_tick === 1'b0, "R8 half_tick", half_tick, 0);
      end
      if (exp_to)
        next_ev = i + timer_eff((wr_at >= 0 && i >= wr_at) ? new_n : n);
      if (i == wr_at) begin wr_lo = 1'b1; wr_byte = new_n[7:0]; end
      if (i == wr_at + 1) wr_lo = 1'b0;
      @(negedge clk);
    end
    check(sck === cpol, {req, " sck"}, sck, cpol);
    spi_en = 1'b1;
  endtask

  task automatic run_spi(input int n, input logic pol, input int halves);
    int ls;
    logic exp_sck;
    spi_en = 1'b1; master_mode = 1'b1; xfer_busy = 1'b0; cpol = pol;
    write_reload(n);
    @(negedge clk); #1;
    check(sck === pol, "R4 idle sck", sck, pol);
    check(half_tick === 1'b0, "R4 idle tick", half_tick, 0);
    xfer_busy = 1'b1;
    ls = spi_eff(n);
    exp_sck = pol;
    for (int i = 0; i < ls * halves; i++) begin
      logic exp_tk;
      #1;
      exp_tk = (i >= ls - 1) && ((i - (ls - 1)) % ls == 0);
      check(half_tick === exp_tk, (n < 2) ? "R3 tick" : "R2 tick", half_tick, exp_tk);
      check(sck === exp_sck, "R2 sck", sck, exp_sck);
      check(timeout === 1'b0, "R8 timeout", timeout, 0);
      if (exp_tk) exp_sck = ~exp_sck;
      @(negedge clk);
    end
    xfer_busy = 1'b0;
    @(negedge clk); #1;
    check(sck === pol, "R4 return to idle", sck, pol);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(sck === 1'b0, "R1 reset sck", sck, 0);
    check(half_tick === 1'b0, "R1 reset tick", half_tick, 0);
    check(timeout === 1'b0, "R1 reset timeout", timeout, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 / R3: serial sweep over reload values and both idle levels
    foreach (int_list[k]) begin
      run_spi(int_list[k], 1'b0, 6);
      run_spi(int_list[k], 1'b1, 6);
    end

    // R4: slave mode with busy high produces no clock
    cpol = 1'b1; master_mode = 1'b0; xfer_busy = 1'b1; spi_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      #1;
      if (half_tick !== 1'b0 || sck !== 1'b1 || timeout !== 1'b0 || i == 29) begin
        check(half_tick === 1'b0, "R4 slave tick", half_tick, 0);
        check(sck === 1'b1, "R4 slave sck", sck, 1);
        check(timeout === 1'b0, "R4 slave timeout", timeout, 0);
      end
      @(negedge clk);
    end
    xfer_busy = 1'b0; cpol = 1'b0;

    // R5: timer sweep
    for (int n = 1; n <= 9; n++) run_timer(n, 5 * n + 4, -1, 0, "R5 timeout");
    // R1: upper byte lands in bits 15:8 (0x0103 = 259)
    run_timer(16'h0103, 600, -1, 0, "R1 hi byte period");
    // R7: mid-count rewrite
    run_timer(10, 40, 3, 4, "R7 deferred reload");
    run_timer(6, 30, 7, 11, "R7 deferred reload");
    // R6: zero reload = 65536 cycles
    run_timer(0, 65540, -1, 0, "R6 zero period");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int int_list [6] = '{0, 1, 2, 3, 5, 7};
endmodule